// File: doc/BRIEF.md
# Strobe-Controlled FIFO with Read Replay

This block is a first-in, first-out word store driven by two active-low strobes rather than by valid/ready handshakes. A low pulse on the write strobe stores one word. A low pulse on the read strobe presents the oldest stored word on the data output. Every strobe is a synchronous input sampled on the system clock. Three active-low flags report empty, full and more-than-half-full. The half-full flag changes only on particular strobe edges. An enable output marks when the data output carries a word, in place of a tri-state bus.

A replay input rewinds the read side to the first location. Everything written since the last reset can then be read again, while the write side is left unchanged. Replay is only meaningful while fewer than the full depth of words have been written since reset. A replay pulse taken while either data strobe is active has no effect and sets a sticky error bit. The word width and the depth (256, 512 or 1024, always a power of two) are parameters.

Top module: `strobe_fifo`

## Requirements
- R1: A write begins in the first cycle that `wr_n` is sampled low while `full_n` is high. The word on `din` is stored in the cycle `wr_n` is sampled high again. Each low pulse stores at most one word, and words leave in the order they were stored.
- R2: A read begins in the first cycle that `rd_n` is sampled low while `empty_n` is high. From the next cycle, `dout_en` is 1 and `dout` holds the oldest unread word. `dout_en` returns to 0 one cycle after `rd_n` is sampled high. While `dout_en` is 0, `dout` is zero.
- R3: `empty_n` is 0 exactly when no unread word is held. It falls in the cycle after the read of the last word begins, while `dout_en` stays 1. It rises in the cycle after a write completes.
- R4: `full_n` is 0 when stored words, plus a write in progress, plus a read in progress, equal the depth. It falls after the write strobe falls and rises only after the read strobe rises.
- R5: `half_n` is 0 when that same held total exceeds half the depth. It falls only when a write begins and rises only when a read ends, or at the end of a replay.
- R6: A read strobe while empty and a write strobe while full change nothing. A strobe held low through that condition is served once it clears: a held read shows a newly written word, and a held write completes after a read frees a location.
- R7: Reset (`rst_n` sampled low) empties the store and sets `empty_n`=0, `full_n`=1, `half_n`=1, `dout_en`=0 and `proto_err`=0.
- R8: With both data strobes high, a low pulse on `rt_n` moves the read position to the first location when `rt_n` rises. The write position is kept, and all flags are recomputed from the restored word count.
- R9: If either data strobe is low, or a transfer is in progress, in any cycle while `rt_n` is low, that replay pulse is ignored and `proto_err` is set. `proto_err` stays 1 until reset.
- R10: A write completion and a read start in the same cycle leave the word count unchanged, and both transfers keep their data order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| rt_n | input | 1 | Active-low replay pulse |
| din | input | WIDTH | Word to store |
| dout | output | WIDTH | Word being read, zero when not enabled |
| dout_en | output | 1 | Data output carries a word |
| empty_n | output | 1 | Low when no unread word is held |
| full_n | output | 1 | Low when no location can be claimed |
| half_n | output | 1 | Low when more than half the depth is held |
| proto_err | output | 1 | Sticky: a replay overlapped a data strobe |

## Verification
Assertions check properties that must hold on every cycle. A transfer may start only when its inhibiting flag was clear. The count never exceeds the depth. Each half-full transition must be caused by a write start, a read end or a replay. A replay must leave the write position alone, and the error bit must stay set. Only the bench scenarios can show the rest: the stored data and its order, the replayed sequence, read-through and held-write completion, and the exact cycle of each half-full crossing against the queue model.

// File: rtl/sfifo_pkg.sv
`timescale 1ns/1ps
// Shared types for the strobe FIFO.
// Assumes nothing beyond a consumer that imports it.
package sfifo_pkg;

    // Per-cycle transfer events decoded from the strobes
    typedef struct packed {
        logic wr_start;
        logic wr_done;
        logic rd_start;
        logic rd_done;
        logic rewind;
    } sfifo_evt_t;

endpackage

// File: rtl/sfifo_store.sv
`timescale 1ns/1ps
// Word storage: one write port and one registered read port.
// Assumes the controller never writes and reads the same live location in one cycle.
module sfifo_store #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] cells [DEPTH];

    // Store a word when a write completes
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    // Fetch the oldest word when a read starts
    always_ff @(posedge clk) begin
        if (re) rdata <= cells[raddr];
    end
endmodule

// File: rtl/sfifo_track.sv
`timescale 1ns/1ps
// Strobe decoding, pointers, occupancy, flags and replay control.
// Assumes strobes are synchronous to clk and DEPTH is a power of two.
module sfifo_track
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic          rt_n,
    output logic          mem_we,
    output logic          mem_re,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic          rd_busy,
    output logic          empty_n,
    output logic          full_n,
    output logic          half_n,
    output logic          proto_err
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

    logic          wr_arm, rd_arm, rt_q, rt_spoil, viol;
    logic [CW-1:0] occ, held;
    sfifo_evt_t    evt;

    // Flags from held locations: unread words plus claimed transfer slots
    always_comb begin
        held    = occ + CW'(wr_arm) + CW'(rd_arm);
        empty_n = (occ != '0);
        full_n  = (held < FULL_CNT);
        half_n  = !(held > HALF_CNT);
    end

    // Decode strobe levels into transfer events
    always_comb begin
        viol         = !wr_n || !rd_n || wr_arm || rd_arm;
        evt.wr_start = !wr_arm && !wr_n && full_n;
        evt.wr_done  = wr_arm && wr_n;
        evt.rd_start = !rd_arm && !rd_n && empty_n;
        evt.rd_done  = rd_arm && rd_n;
        evt.rewind   = !rt_q && rt_n && !rt_spoil && !viol;
    end

    // Transfer state, pointers and word count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_arm <= 1'b0;
            rd_arm <= 1'b0;
            wptr   <= '0;
            rptr   <= '0;
            occ    <= '0;
        end else begin
            if (evt.wr_done)       wr_arm <= 1'b0;
            else if (evt.wr_start) wr_arm <= 1'b1;
            if (evt.rd_done)       rd_arm <= 1'b0;
            else if (evt.rd_start) rd_arm <= 1'b1;
            if (evt.wr_done) wptr <= wptr + AW'(1);
            if (evt.rewind) begin
                rptr <= '0;
                occ  <= {1'b0, wptr};
            end else begin
                if (evt.rd_start) rptr <= rptr + AW'(1);
                occ <= occ + CW'(evt.wr_done) - CW'(evt.rd_start);
            end
        end
    end

    // Replay pulse tracking and sticky protocol error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_q      <= 1'b1;
            rt_spoil  <= 1'b0;
            proto_err <= 1'b0;
        end else begin
            rt_q      <= rt_n;
            rt_spoil  <= rt_n ? 1'b0 : (rt_spoil || viol);
            proto_err <= proto_err || (!rt_n && viol);
        end
    end

    assign mem_we  = evt.wr_done;
    assign mem_re  = evt.rd_start;
    assign rd_busy = rd_arm;

    // R6
    wr_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_arm) |-> $past(full_n));
    // R6
    rd_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_arm) |-> $past(empty_n));
    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_arm |-> !$past(rd_n));
    // R4
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= FULL_CNT);
    // R5
    half_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(half_n) |-> ($rose(wr_arm) || $past(evt.rewind)));
    // R5
    half_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(half_n) |-> ($fell(rd_arm) || $past(evt.rewind)));
    // R8
    rewind_keep_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rt_n && wr_n && !wr_arm) |=> $stable(wptr));
    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
endmodule

// File: rtl/strobe_fifo.sv
`timescale 1ns/1ps
// Strobe-controlled FIFO with read replay: joins control and storage.
// Assumes synchronous strobes; replay valid only before the depth wraps.
module strobe_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             rt_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             dout_en,
    output logic             empty_n,
    output logic             full_n,
    output logic             half_n,
    output logic             proto_err
);
    localparam int AW = $clog2(DEPTH);

    logic             mem_we, mem_re, rd_busy;
    logic [AW-1:0]    wptr, rptr;
    logic [WIDTH-1:0] rdata;

    sfifo_track #(.DEPTH(DEPTH)) u_track (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
        .mem_we(mem_we), .mem_re(mem_re), .wptr(wptr), .rptr(rptr),
        .rd_busy(rd_busy), .empty_n(empty_n), .full_n(full_n),
        .half_n(half_n), .proto_err(proto_err)
    );

    sfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk(clk), .we(mem_we), .waddr(wptr), .wdata(din),
        .re(mem_re), .raddr(rptr), .rdata(rdata)
    );

    // Drive data only while a read is in progress
    always_comb begin
        dout_en = rd_busy;
        dout    = rd_busy ? rdata : '0;
    end
endmodule

// File: tb/sim_strobe_fifo.sv
`timescale 1ns/1ps
module sim_strobe_fifo;
    localparam int D = 256;
    localparam int W = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0, wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic dout_en, empty_n, full_n, half_n, proto_err;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0, mvalid = 0;

    // reference model state
    int hist[$];
    int ridx = 0, exp_dout = 0;
    bit wact = 0, ract = 0, perr = 0, rt_prev = 1, rt_bad = 0;

    strobe_fifo #(.WIDTH(W), .DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
        .din(din), .dout(dout), .dout_en(dout_en), .empty_n(empty_n),
        .full_n(full_n), .half_n(half_n), .proto_err(proto_err)
    );

    always #2 clk = ~clk;

    task automatic check(string r, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", r, act, exp, $time);
        end
    endtask

    // model update at each edge, then compare outputs 1 ns later
    always @(posedge clk) begin
        int cnt, held;
        bit wdone, rdone, wstart, rstart, viol, rew;
        if (!rst_n) begin
            hist.delete(); ridx = 0; wact = 0; ract = 0; perr = 0;
            rt_prev = 1; rt_bad = 0; mvalid = 1;
        end else if (mvalid) begin
            cnt    = hist.size() - ridx;
            held   = cnt + int'(wact) + int'(ract);
            wdone  = wact && wr_n;
            rdone  = ract && rd_n;
            wstart = !wact && !wr_n && held < D;
            rstart = !ract && !rd_n && cnt > 0;
            viol   = !wr_n || !rd_n || wact || ract;
            rew    = !rt_prev && rt_n && !rt_bad && !viol;
            if (rstart) begin exp_dout = hist[ridx]; ridx++; end
            if (wdone) hist.push_back(int'(din));
            if (rew) ridx = 0;
            wact = wdone ? 0 : (wstart ? 1 : wact);
            ract = rdone ? 0 : (rstart ? 1 : ract);
            rt_bad = rt_n ? 0 : (rt_bad || viol);
            perr = perr || (!rt_n && viol);
            rt_prev = rt_n;
        end
        #1;
        if (mvalid && !done) begin
            cnt  = hist.size() - ridx;
            held = cnt + int'(wact) + int'(ract);
            check("R3 empty_n", int'(empty_n), int'(cnt > 0));
            check("R4 full_n", int'(full_n), int'(held < D));
            check("R5 half_n", int'(half_n), int'(!(held > D/2)));
            check("R2 dout_en", int'(dout_en), int'(ract));
            check("R1 dout", int'(dout), ract ? exp_dout : 0);
            check("R9 proto_err", int'(proto_err), int'(perr));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1; total++; bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 50000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic put(int d);
        @(negedge clk) begin wr_n = 0; din = W'(d); end
        @(negedge clk);
        @(negedge clk) wr_n = 1;
        @(negedge clk);
    endtask

    task automatic get();
        @(negedge clk) rd_n = 0;
        @(negedge clk);
        @(negedge clk) rd_n = 1;
        @(negedge clk);
    endtask

    task automatic get_exp(string r, int e);
        @(negedge clk) rd_n = 0;
        @(negedge clk);
        check(r, int'(dout), e);
        check(r, int'(dout_en), 1);
        rd_n = 1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic retx();
        @(negedge clk) rt_n = 0;
        @(negedge clk);
        @(negedge clk) rt_n = 1;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 0;
        @(negedge clk);
        @(negedge clk) rst_n = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R7 reset state
        check("R7 empty_n", int'(empty_n), 0);
        check("R7 full_n", int'(full_n), 1);
        check("R7 half_n", int'(half_n), 1);
        check("R7 dout_en", int'(dout_en), 0);
        check("R7 proto_err", int'(proto_err), 0);

        // R6 read on empty is ignored
        @(negedge clk) rd_n = 0;
        @(negedge clk);
        check("R6 rd empty", int'(dout_en), 0);
        @(negedge clk) rd_n = 1;
        @(negedge clk);
        check("R6 rd empty", int'(empty_n), 0);

        // R1 R2 basic order
        for (int i = 0; i < 5; i++) put('h101 + i);
        check("R3 after writes", int'(empty_n), 1);
        get_exp("R2 first", 'h101);
        get_exp("R1 second", 'h102);
        get_exp("R1 third", 'h103);

        // R8 replay from the first location
        retx();
        check("R8 flags after replay", int'(empty_n), 1);
        get_exp("R8 replay", 'h101);
        for (int i = 0; i < 4; i++) get();
        check("R3 drained", int'(empty_n), 0);

        // R6 read-through with the read strobe held low
        @(negedge clk) rd_n = 0;
        @(negedge clk);
        check("R6 held rd waits", int'(dout_en), 0);
        put('h1AA);
        @(negedge clk);
        check("R6 read-through", int'(dout), 'h1AA);
        check("R3 last read", int'(empty_n), 0);
        // R9 replay during active read is ignored
        retx();
        check("R9 err set", int'(proto_err), 1);
        @(negedge clk) rd_n = 1;
        @(negedge clk);
        @(negedge clk);
        check("R9 no rewind", int'(empty_n), 0);

        // R7 reset clears the error
        do_reset();
        check("R7 err cleared", int'(proto_err), 0);

        // R4 R5 fill to depth
        for (int i = 0; i < D; i++) begin
            put((i * 7 + 3) & 'h1FF);
            if (i == D/2 - 1) check("R5 at half", int'(half_n), 1);
            if (i == D/2) check("R5 over half", int'(half_n), 0);
        end
        check("R4 full", int'(full_n), 0);
        put('h0FF);   // R6 ignored while full
        check("R6 wr full", int'(full_n), 0);

        // R6 held write completes after a read frees a location
        @(negedge clk) begin wr_n = 0; din = 'h1EE; end
        get_exp("R6 oldest", 3);
        check("R4 reclaimed", int'(full_n), 0);
        @(negedge clk) wr_n = 1;
        @(negedge clk);

        // R5 hysteresis on the way down
        for (int j = 1; j <= D/2; j++) begin
            get();
            if (j == D/2 - 1) check("R5 still low", int'(half_n), 0);
            if (j == D/2) check("R5 back high", int'(half_n), 1);
        end
        for (int j = 0; j < D/2 - 1; j++) get();
        get_exp("R6 held word", 'h1EE);
        check("R3 empty again", int'(empty_n), 0);

        // R10 coincident write and read
        put('h011); put('h022);
        @(negedge clk) begin wr_n = 0; rd_n = 0; din = 'h033; end
        @(negedge clk);
        @(negedge clk) begin wr_n = 1; rd_n = 1; end
        @(negedge clk);
        @(negedge clk);
        check("R10 not empty", int'(empty_n), 1);
        get_exp("R10 order", 'h022);
        get_exp("R10 order", 'h033);
        check("R10 drained", int'(empty_n), 0);

        repeat (4) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule